// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder

This block adds a parameterised number of unsigned operands in one combinational pass. The operands go through a row of 3:2 compressors, and then through one more row for each further operand. Each row is a set of independent full adders, one per bit position, and no carry ripples between positions inside a row. Between rows the result stays as two vectors: a sum vector and a carry vector. The carry vector has twice the bit weight of the sum vector, so it is moved up one position, with a zero entering at bit 0, before the next row consumes it. After the last row, one carry-propagate adder merges the two vectors into the binary total.

With NOPS operands there are NOPS-2 compressor rows and only one carry-propagate add. A chain of adders would need NOPS-1 of them. The result is OPW + ceil(log2(NOPS)) bits wide, so even the largest possible total fits. Every internal vector is widened to that width, so no carry is lost. All operands are packed into one flat input bus, with operand i in bits [i*OPW +: OPW]. The block has no clock and no state: the total follows the operands.

Top module: `multi_operand_csa_adder`

## Requirements
- R1: For any operand values, `total` equals the exact arithmetic sum of all NOPS operands, each taken as an unsigned OPW-bit number from bits [i*OPW +: OPW] of `ops_flat`.
- R2: `total` is OPW + ceil(log2(NOPS)) bits wide and never wraps. With every operand all ones, it reads NOPS*(2^OPW-1), which is 1275 for the default OPW=8 and NOPS=5.
- R3: When every operand is zero, `total` is zero.
- R4: The order of the operands has no effect. Rotating the operands among the operand slots leaves `total` unchanged.
- R5: Carries keep their weight between rows. When every operand holds the single bit 2^j, `total` equals NOPS*2^j for every j from 0 to OPW-1, including the top bit. Each compressor row also conserves value: its sum vector plus twice its carry vector equals the sum of its three inputs.
- R6: The small worked case holds. Operands 1, 7, 13 and 2, with any remaining operands zero, give a total of 23 (binary 10111).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_flat | input | NOPS*OPW | All operands packed; operand i occupies bits [i*OPW +: OPW] |
| total | output | OPW+$clog2(NOPS) | Exact unsigned sum of all operands |

## Verification
Several kinds of input are used, and each tells a different fault apart.

- Random operands exercise mixed carries at all rows at once, so they expose wrong majority or parity logic anywhere.
- All-ones operands drive the maximum carry count into the top columns, which shows a truncated internal width or a dropped final carry.
- Operands holding one equal bit place the whole sum in a single column, which shows a carry shifted by the wrong amount or lost at a given position.
- Rotating a fixed set of operands through the slots shows an operand wired to the wrong row or an operand ignored.

// File: rtl/mocsa_pkg.sv
package mocsa_pkg;

    // Width that holds the sum of nops unsigned values of opw bits
    function automatic int sum_width(input int opw, input int nops);
        return opw + $clog2(nops);
    endfunction

endpackage

// File: rtl/mocsa_fa_cell.sv
module mocsa_fa_cell (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ c;
    assign co = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/mocsa_csa_row.sv
module mocsa_csa_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] sum_v,
    output logic [W-1:0] car_v
);
    // One independent full adder per column; nothing crosses columns here
    for (genvar i = 0; i < W; i++) begin : g_col
        mocsa_fa_cell u_fa (
            .a  (in_a[i]),
            .b  (in_b[i]),
            .c  (in_c[i]),
            .s  (sum_v[i]),
            .co (car_v[i])
        );
    end
endmodule

// File: rtl/mocsa_cpa.sv
module mocsa_cpa #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] z
);
    logic rc;

    // Ripple merge of the two redundant vectors
    always_comb begin
        rc = 1'b0;
        z  = '0;
        for (int i = 0; i < W; i++) begin
            z[i] = x[i] ^ y[i] ^ rc;
            rc   = (x[i] & y[i]) | (rc & (x[i] ^ y[i]));
        end
    end
endmodule

// File: rtl/multi_operand_csa_adder.sv
module multi_operand_csa_adder #(
    parameter int OPW  = 8,
    parameter int NOPS = 5
) (
    input  logic [NOPS*OPW-1:0]          ops_flat,
    output logic [OPW+$clog2(NOPS)-1:0]  total
);
    localparam int SUMW = mocsa_pkg::sum_width(OPW, NOPS);
    localparam int NLAY = NOPS - 2;

    logic [NOPS-1:0][SUMW-1:0] opx;
    logic [NLAY-1:0][SUMW-1:0] row_a;
    logic [NLAY-1:0][SUMW-1:0] row_b;
    logic [NLAY-1:0][SUMW-1:0] row_c;
    logic [NLAY-1:0][SUMW-1:0] row_s;
    logic [NLAY-1:0][SUMW-1:0] row_k;
    logic [SUMW-1:0]           fin_car;

    // Zero-extend every operand to the full result width
    for (genvar g = 0; g < NOPS; g++) begin : g_ext
        assign opx[g] = SUMW'(ops_flat[g*OPW +: OPW]);
    end

    // Linear chain of compressor rows; carry moves up one column between rows
    for (genvar l = 0; l < NLAY; l++) begin : g_lay
        if (l == 0) begin : g_first
            assign row_a[l] = opx[0];
            assign row_b[l] = opx[1];
        end else begin : g_next
            assign row_a[l] = row_s[l-1];
            assign row_b[l] = row_k[l-1] << 1;
        end
        assign row_c[l] = opx[l+2];

        mocsa_csa_row #(.W(SUMW)) u_row (
            .in_a  (row_a[l]),
            .in_b  (row_b[l]),
            .in_c  (row_c[l]),
            .sum_v (row_s[l]),
            .car_v (row_k[l])
        );
    end

    assign fin_car = row_k[NLAY-1] << 1;

    mocsa_cpa #(.W(SUMW)) u_cpa (
        .x (row_s[NLAY-1]),
        .y (fin_car),
        .z (total)
    );
endmodule

// File: rtl/mocsa_checker.sv
module mocsa_checker #(
    parameter int OPW  = 8,
    parameter int NOPS = 5,
    parameter int SUMW = 11,
    parameter int NLAY = 3
) (
    input logic [NOPS*OPW-1:0]      ops_flat,
    input logic [SUMW-1:0]          total,
    input logic [NLAY-1:0][SUMW-1:0] row_a,
    input logic [NLAY-1:0][SUMW-1:0] row_b,
    input logic [NLAY-1:0][SUMW-1:0] row_c,
    input logic [NLAY-1:0][SUMW-1:0] row_s,
    input logic [NLAY-1:0][SUMW-1:0] row_k
);
    localparam logic [SUMW-1:0] MAXV =
        SUMW'(NOPS) * {{(SUMW-OPW){1'b0}}, {OPW{1'b1}}};

    logic [SUMW-1:0] ref_sum;

    always_comb begin
        ref_sum = '0;
        for (int i = 0; i < NOPS; i++) begin
            ref_sum = ref_sum + SUMW'(ops_flat[i*OPW +: OPW]);
        end
    end

    always_comb begin
        AST_EXACT_SUM: assert (total == ref_sum); // R1
        AST_NO_OVERFLOW: assert (total <= MAXV); // R2
        if (ops_flat == '0) begin
            AST_ZERO_IN: assert (total == '0); // R3
        end
    end

    for (genvar l = 0; l < NLAY; l++) begin : g_lchk
        always_comb begin
            AST_LAYER_CONSERVE: assert ((SUMW+2)'(row_s[l]) + ((SUMW+2)'(row_k[l]) << 1) == (SUMW+2)'(row_a[l]) + (SUMW+2)'(row_b[l]) + (SUMW+2)'(row_c[l])); // R5
        end
    end
endmodule

bind multi_operand_csa_adder mocsa_checker #(
    .OPW  (OPW),
    .NOPS (NOPS),
    .SUMW (SUMW),
    .NLAY (NLAY)
) u_chk (
    .ops_flat (ops_flat),
    .total    (total),
    .row_a    (row_a),
    .row_b    (row_b),
    .row_c    (row_c),
    .row_s    (row_s),
    .row_k    (row_k)
);

// File: tb/multi_operand_csa_adder_test.sv
module multi_operand_csa_adder_test;
    localparam int OPW  = 8;
    localparam int NOPS = 5;
    localparam int SUMW = OPW + $clog2(NOPS);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NOPS*OPW-1:0] ops_flat = '0;
    logic [SUMW-1:0]     total;
    int                  opv [NOPS];
    int                  n_total = 0;
    int                  n_fail = 0;
    bit                  done = 1'b0;

    always #4 clk = ~clk;

    multi_operand_csa_adder #(.OPW(OPW), .NOPS(NOPS)) uut (
        .ops_flat (ops_flat),
        .total    (total)
    );

    function automatic longint model_sum();
        longint s = 0;
        for (int i = 0; i < NOPS; i++) s += longint'(opv[i]);
        return s;
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        n_total++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: total=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Present opv on the bus after a rising edge, then sample at the falling edge
    task automatic apply();
        @(posedge clk);
        for (int i = 0; i < NOPS; i++) ops_flat[i*OPW +: OPW] = OPW'(opv[i]);
        @(negedge clk);
    endtask

    task automatic set_all(input int v);
        for (int i = 0; i < NOPS; i++) opv[i] = v;
    endtask

    initial begin
        longint held;
        int     tmp;
        set_all(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R3 reset zero", longint'(total), 0);
        rst_n = 1'b1;

        set_all(0);
        apply();
        check("R3 all zero", longint'(total), 0);

        set_all((1 << OPW) - 1);
        apply();
        check("R2 all ones", longint'(total), longint'(NOPS) * ((1 << OPW) - 1));

        set_all(0);
        opv[0] = 1; opv[1] = 7; opv[2] = 13; opv[3] = 2;
        apply();
        check("R6 worked case", longint'(total), 23);

        for (int j = 0; j < OPW; j++) begin
            set_all(1 << j);
            apply();
            check("R5 column weight", longint'(total), longint'(NOPS) << j);
        end

        set_all(0);
        opv[NOPS-1] = (1 << OPW) - 1;
        apply();
        check("R1 last slot only", longint'(total), (1 << OPW) - 1);

        for (int i = 0; i < NOPS; i++) opv[i] = (i * 37 + 11) % (1 << OPW);
        apply();
        held = longint'(total);
        check("R1 fixed mix", held, model_sum());
        for (int r = 0; r < NOPS - 1; r++) begin
            tmp = opv[0];
            for (int i = 0; i < NOPS - 1; i++) opv[i] = opv[i+1];
            opv[NOPS-1] = tmp;
            apply();
            check("R4 rotated order", longint'(total), held);
        end

        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NOPS; i++) opv[i] = int'($urandom_range((1 << OPW) - 1, 0));
            apply();
            check("R1 random", longint'(total), model_sum());
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: total=%0d expected=completion", total);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule